// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block holds the status and handshake logic of one single-buffered USB device endpoint. Firmware drives it through a status register and a byte-wide FIFO port. The bus side is a simplified packet interface. It presents decoded SETUP, OUT and IN token strobes, received data-byte strobes, an end-of-packet strobe, a transmit pop and end strobe, and a strobe for an ACK from the host. The block owns one 64-byte packet FIFO that both directions share.

For every IN token and every received data packet, the block decides whether the endpoint sends data, answers ACK, or answers NAK. It keeps four flags: transmit-ready, transmit-done, setup-pending and receive-full. Firmware and the device share these flags through a set/clear handshake. Firmware sets transmit-ready by writing a 1. Firmware clears each device-set flag by writing a 0, so a firmware write can never erase an event that the device sets in the same cycle. The endpoint interrupt is raised whenever a device-set flag is pending.

A typical IN transfer runs as follows. Firmware loads the bytes and sets transmit-ready. The bus side drains the FIFO after a DATA response, and transmit-ready drops as soon as the packet has gone out. Transmit-done rises when the host ACKs the packet.

Top module: `usb_ep_hs`

## Requirements
- R1: After reset, all four flags are clear, the byte count reads 0, the interrupt is low and no handshake is issued.
- R2: A firmware FIFO write is stored only while transmit-ready is clear and no bus packet is in progress. The byte count in status bits [14:8] rises by one for each stored byte.
- R3: Writing 1 to status bit 3 sets transmit-ready, and writing 0 to it has no effect. The cycle after an IN token, hs_vld is 1. hs_code is 2 (send data) if transmit-ready was set and 1 (NAK) if it was clear.
- R4: The transmit end strobe after a DATA response clears transmit-ready. A following host ACK sets transmit-done (status bit 0). An ACK with no packet awaiting acknowledgement has no effect.
- R5: Status bits 0 (transmit-done), 1 (setup-pending) and 2 (receive-full) clear when written 0 and keep their value when written 1. A device set in the same cycle as a clearing write wins.
- R6: ep_irq is high exactly while at least one of transmit-done, setup-pending or receive-full is set.
- R7: A SETUP token always flushes the FIFO and cancels a pending transmit-ready. The setup bytes are stored, and at end of packet setup-pending is set and hs_code 0 (ACK) is issued.
- R8: An OUT packet that arrives while setup-pending is set is answered with NAK, and its bytes are discarded, leaving the FIFO unchanged.
- R9: An OUT packet that arrives with setup-pending, receive-full and transmit-ready all clear flushes the FIFO and stores its bytes. The count reports them, receive-full is set and ACK is issued.
- R10: An OUT packet that arrives while receive-full or transmit-ready is set is answered with NAK, and the FIFO content is kept.
- R11: Bytes leave the FIFO in the order they entered, through both the firmware read port and the transmit port.
- R12: A firmware write that clears setup-pending or receive-full flushes the FIFO, and the count reads 0.
- R13: Received bytes beyond the 64-byte FIFO depth are dropped, and the count stops at 64.
- R14: A zero-length IN packet is legal. With transmit-ready set and an empty FIFO, an IN token gets the DATA response, and the ACK sets transmit-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_stat_wr | input | 1 | Status register write strobe |
| fw_stat_wdata | input | 4 | Status write data: bits 0-2 write-0-to-clear, bit 3 write-1-to-set |
| fw_stat_rdata | output | 16 | Flags in bits 3:0, byte count in bits 14:8 |
| fw_fifo_wr | input | 1 | Firmware FIFO write strobe |
| fw_fifo_wdata | input | 8 | Firmware FIFO write byte |
| fw_fifo_rd | input | 1 | Firmware FIFO pop strobe |
| fw_fifo_rdata | output | 8 | Byte at the FIFO head |
| ep_irq | output | 1 | Endpoint interrupt |
| bus_setup_tok | input | 1 | SETUP token strobe |
| bus_out_tok | input | 1 | OUT token strobe |
| bus_in_tok | input | 1 | IN token strobe |
| bus_rx_vld | input | 1 | Received data byte strobe |
| bus_rx_byte | input | 8 | Received data byte |
| bus_pkt_end | input | 1 | End of received data packet |
| bus_tx_pop | input | 1 | Transmit side takes the head byte |
| bus_tx_byte | output | 8 | Byte at the FIFO head, for transmission |
| bus_tx_end | input | 1 | IN data packet fully sent |
| bus_host_ack | input | 1 | ACK handshake received from the host |
| hs_vld | output | 1 | Handshake decision valid for one cycle |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 send data |

## Verification
The in-RTL assertions check several rules on every cycle. The FIFO count never passes its depth and never moves without a push, pop or flush. An IN token with transmit-ready clear always yields a NAK, and an OUT during a pending setup goes to the discard path. Transmit-done rises only after a host ACK, and writing 1 to a set device flag never clears it. Other behaviour shows only in the directed scenarios. These include the byte ordering through both read ports, and the flush on a firmware clear. They also cover the race in which a clearing write and a device set land in the same cycle, and the cancellation of a pending IN packet by SETUP. The saturation at 64 bytes and the zero-length IN packet are covered there as well.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    localparam int STAT_W = 16;
    localparam int CNT_LSB = 8;

    typedef enum logic [1:0] {
        RESP_ACK  = 2'd0,
        RESP_NAK  = 2'd1,
        RESP_DATA = 2'd2
    } resp_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_KEEP  = 2'd2,
        PH_DROP  = 2'd3
    } phase_e;

    // Packed so that bit 0 is transmit-done and bit 3 is transmit-ready.
    typedef struct packed {
        logic tx_rdy;
        logic rx_full;
        logic setup;
        logic tx_done;
    } ep_flags_t;

    function automatic logic [STAT_W-1:0] pack_status(input ep_flags_t f,
                                                       input logic [7:0] cnt);
        logic [STAT_W-1:0] w;
        w = '0;
        w[3:0] = f;
        w[CNT_LSB +: 8] = cnt;
        return w;
    endfunction

endpackage

// File: rtl/ep_fifo.sv
module ep_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr, do_rd;

    assign full    = (count == CW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && (count != '0);
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr && !flush) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= inc(wr_ptr);
            if (do_rd) rd_ptr <= inc(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r13: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!flush && !wr_en && !rd_en) |=> $stable(count));

endmodule

// File: rtl/ep_flags.sv
module ep_flags
    import usb_ep_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic [3:0] wdata,
    input  logic      set_setup,
    input  logic      set_rx,
    input  logic      set_txdone,
    input  logic      clr_txrdy,
    output ep_flags_t flags,
    output logic      fw_flush
);
    ep_flags_t nxt;
    logic keep_done, keep_setup, keep_rx;

    // Write-0-to-clear: a written 1 (or no write) keeps the flag.
    assign keep_done  = !wr || wdata[0];
    assign keep_setup = !wr || wdata[1];
    assign keep_rx    = !wr || wdata[2];

    always_comb begin
        nxt.tx_done = (flags.tx_done & keep_done)  | set_txdone;
        nxt.setup   = (flags.setup   & keep_setup) | set_setup;
        nxt.rx_full = (flags.rx_full & keep_rx)    | set_rx;
        nxt.tx_rdy  = (flags.tx_rdy  & !clr_txrdy) | (wr & wdata[3]);
    end

    // Firmware releasing a received buffer empties the shared FIFO.
    assign fw_flush = (flags.setup   && !keep_setup && !set_setup) ||
                      (flags.rx_full && !keep_rx    && !set_rx);

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end

    p_w1_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[0] && flags.tx_done) |=> flags.tx_done);

endmodule

// File: rtl/ep_bus_seq.sv
module ep_bus_seq
    import usb_ep_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   setup_tok,
    input  logic   out_tok,
    input  logic   in_tok,
    input  logic   rx_vld,
    input  logic   pkt_end,
    input  logic   tx_pop_req,
    input  logic   tx_end,
    input  logic   host_ack,
    input  logic   setup_f,
    input  logic   rx_f,
    input  logic   txrdy_f,
    input  logic   fifo_full,
    output logic   rx_store,
    output logic   flush,
    output logic   tx_pop,
    output logic   set_setup,
    output logic   set_rx,
    output logic   set_txdone,
    output logic   clr_txrdy,
    output logic   busy,
    output logic   hs_vld,
    output resp_e  hs_code
);
    phase_e phase;
    logic   sending, await_ack;
    logic   any_tok, out_ok;

    assign any_tok = setup_tok | out_tok | in_tok;
    assign out_ok  = !setup_f && !rx_f && !txrdy_f;
    assign busy    = (phase != PH_IDLE) || sending;

    always_comb begin
        flush      = 1'b0;
        clr_txrdy  = 1'b0;
        set_setup  = 1'b0;
        set_rx     = 1'b0;
        if (setup_tok) begin
            flush     = 1'b1;
            clr_txrdy = 1'b1;
        end else if (out_tok) begin
            flush = out_ok;
        end else begin
            if (pkt_end && phase == PH_SETUP) set_setup = 1'b1;
            if (pkt_end && phase == PH_KEEP)  set_rx    = 1'b1;
            if (tx_end && sending)            clr_txrdy = 1'b1;
        end
        rx_store   = rx_vld && !fifo_full &&
                     (phase == PH_SETUP || phase == PH_KEEP);
        tx_pop     = tx_pop_req && sending;
        set_txdone = host_ack && await_ack && !any_tok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            sending   <= 1'b0;
            await_ack <= 1'b0;
            hs_vld    <= 1'b0;
            hs_code   <= RESP_ACK;
        end else begin
            hs_vld <= 1'b0;
            if (setup_tok) begin
                phase     <= PH_SETUP;
                sending   <= 1'b0;
                await_ack <= 1'b0;
            end else if (out_tok) begin
                phase     <= out_ok ? PH_KEEP : PH_DROP;
                sending   <= 1'b0;
                await_ack <= 1'b0;
            end else if (in_tok) begin
                hs_vld    <= 1'b1;
                hs_code   <= txrdy_f ? RESP_DATA : RESP_NAK;
                sending   <= txrdy_f;
                await_ack <= 1'b0;
            end else begin
                if (pkt_end && phase != PH_IDLE) begin
                    hs_vld  <= 1'b1;
                    hs_code <= (phase == PH_DROP) ? RESP_NAK : RESP_ACK;
                    phase   <= PH_IDLE;
                end
                if (tx_end && sending) begin
                    sending   <= 1'b0;
                    await_ack <= 1'b1;
                end else if (host_ack && await_ack) begin
                    await_ack <= 1'b0;
                end
            end
        end
    end

    p_in_nak_r3: assert property (@(posedge clk) disable iff (rst)
        (in_tok && !setup_tok && !out_tok && !txrdy_f) |=>
            (hs_vld && hs_code == RESP_NAK));

    p_out_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (out_tok && !setup_tok && setup_f) |=> (phase == PH_DROP));

    p_drop_nak_r10: assert property (@(posedge clk) disable iff (rst)
        (pkt_end && !any_tok && phase == PH_DROP) |=>
            (hs_vld && hs_code == RESP_NAK));

endmodule

// File: rtl/usb_ep_hs.sv
module usb_ep_hs
    import usb_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fw_stat_wr,
    input  logic [3:0]  fw_stat_wdata,
    output logic [15:0] fw_stat_rdata,
    input  logic        fw_fifo_wr,
    input  logic [7:0]  fw_fifo_wdata,
    input  logic        fw_fifo_rd,
    output logic [7:0]  fw_fifo_rdata,
    output logic        ep_irq,
    input  logic        bus_setup_tok,
    input  logic        bus_out_tok,
    input  logic        bus_in_tok,
    input  logic        bus_rx_vld,
    input  logic [7:0]  bus_rx_byte,
    input  logic        bus_pkt_end,
    input  logic        bus_tx_pop,
    output logic [7:0]  bus_tx_byte,
    input  logic        bus_tx_end,
    input  logic        bus_host_ack,
    output logic        hs_vld,
    output logic [1:0]  hs_code
);
    ep_flags_t flags;
    resp_e     code;
    logic      rx_store, seq_flush, fw_flush, tx_pop;
    logic      set_setup, set_rx, set_txdone, clr_txrdy, busy;
    logic      fifo_full, fifo_wr, fifo_rd;
    logic [7:0] fifo_wdata, head;
    logic [CW-1:0] count;

    ep_flags u_flags (
        .clk, .rst,
        .wr(fw_stat_wr), .wdata(fw_stat_wdata),
        .set_setup, .set_rx, .set_txdone, .clr_txrdy,
        .flags, .fw_flush
    );

    ep_bus_seq u_seq (
        .clk, .rst,
        .setup_tok(bus_setup_tok), .out_tok(bus_out_tok), .in_tok(bus_in_tok),
        .rx_vld(bus_rx_vld), .pkt_end(bus_pkt_end),
        .tx_pop_req(bus_tx_pop), .tx_end(bus_tx_end), .host_ack(bus_host_ack),
        .setup_f(flags.setup), .rx_f(flags.rx_full), .txrdy_f(flags.tx_rdy),
        .fifo_full,
        .rx_store, .flush(seq_flush), .tx_pop,
        .set_setup, .set_rx, .set_txdone, .clr_txrdy, .busy,
        .hs_vld, .hs_code(code)
    );

    assign fifo_wr    = rx_store | (fw_fifo_wr & !flags.tx_rdy & !busy);
    assign fifo_wdata = rx_store ? bus_rx_byte : fw_fifo_wdata;
    assign fifo_rd    = tx_pop | (fw_fifo_rd & !bus_tx_pop);

    ep_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk, .rst,
        .flush(seq_flush | fw_flush),
        .wr_en(fifo_wr), .wr_data(fifo_wdata),
        .rd_en(fifo_rd), .rd_data(head),
        .count, .full(fifo_full)
    );

    assign fw_fifo_rdata = head;
    assign bus_tx_byte   = head;
    assign hs_code       = code;
    assign ep_irq        = flags.tx_done | flags.setup | flags.rx_full;
    assign fw_stat_rdata = pack_status(flags, 8'(count));

    p_txdone_ack_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.tx_done) |-> $past(bus_host_ack));

    p_fw_blocked_r2: assert property (@(posedge clk) disable iff (rst)
        (fw_fifo_wr && flags.tx_rdy && !bus_tx_pop && !bus_rx_vld &&
         !bus_setup_tok && !bus_out_tok && !fw_stat_wr) |=> $stable(count));

endmodule

// File: tb/test_usb_ep_hs.sv
module test_usb_ep_hs;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fw_stat_wr = 0, fw_fifo_wr = 0, fw_fifo_rd = 0;
    logic [3:0] fw_stat_wdata = 0;
    logic [7:0] fw_fifo_wdata = 0, bus_rx_byte = 0;
    logic bus_setup_tok = 0, bus_out_tok = 0, bus_in_tok = 0, bus_rx_vld = 0;
    logic bus_pkt_end = 0, bus_tx_pop = 0, bus_tx_end = 0, bus_host_ack = 0;
    logic [15:0] fw_stat_rdata;
    logic [7:0]  fw_fifo_rdata, bus_tx_byte;
    logic        ep_irq, hs_vld;
    logic [1:0]  hs_code;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_ep_hs i_usb_ep_hs (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] cnt();  return fw_stat_rdata[14:8]; endfunction

    task automatic stat_write(input logic [3:0] d);
        fw_stat_wr = 1; fw_stat_wdata = d;
        @(negedge clk);
        fw_stat_wr = 0; fw_stat_wdata = 0;
    endtask

    task automatic fw_push(input logic [7:0] b);
        fw_fifo_wr = 1; fw_fifo_wdata = b;
        @(negedge clk);
        fw_fifo_wr = 0;
    endtask

    task automatic fw_pop();
        fw_fifo_rd = 1; @(negedge clk); fw_fifo_rd = 0;
    endtask

    task automatic in_token(output logic v, output logic [1:0] c);
        bus_in_tok = 1; @(negedge clk); bus_in_tok = 0;
        v = hs_vld; c = hs_code;
    endtask

    task automatic pulse_tx_end();
        bus_tx_end = 1; @(negedge clk); bus_tx_end = 0;
    endtask

    task automatic pulse_ack();
        bus_host_ack = 1; @(negedge clk); bus_host_ack = 0;
    endtask

    // setup_pkt: 1 for SETUP, 0 for OUT
    task automatic rx_packet(input logic setup_pkt, input int n, input logic [7:0] base,
                             output logic v, output logic [1:0] c);
        if (setup_pkt) bus_setup_tok = 1; else bus_out_tok = 1;
        @(negedge clk);
        bus_setup_tok = 0; bus_out_tok = 0;
        for (int i = 0; i < n; i++) begin
            bus_rx_vld = 1; bus_rx_byte = base + 8'(i);
            @(negedge clk);
        end
        bus_rx_vld = 0;
        bus_pkt_end = 1; @(negedge clk); bus_pkt_end = 0;
        v = hs_vld; c = hs_code;
    endtask

    task automatic t_reset();
        check("R1 status", fw_stat_rdata, 0);
        check("R1 irq", ep_irq, 0);
        check("R1 hs_vld", hs_vld, 0);
    endtask

    task automatic t_in_path();
        logic v; logic [1:0] c;
        fw_push(8'hA1); fw_push(8'hA2); fw_push(8'hA3);
        check("R2 count after load", cnt(), 3);
        stat_write(4'b0000);
        check("R3 write0 no set", fw_stat_rdata[3], 0);
        stat_write(4'b1111);
        check("R3 tx_ready set", fw_stat_rdata[3], 1);
        fw_push(8'hFF);
        check("R2 write blocked", cnt(), 3);
        in_token(v, c);
        check("R3 data resp vld", v, 1);
        check("R3 data resp code", c, 2);
        for (int i = 0; i < 3; i++) begin
            check("R11 tx order", bus_tx_byte, 8'hA1 + 8'(i));
            bus_tx_pop = 1; @(negedge clk); bus_tx_pop = 0;
        end
        pulse_tx_end();
        check("R4 tx_ready cleared", fw_stat_rdata[3], 0);
        check("R4 no done before ack", fw_stat_rdata[0], 0);
        pulse_ack();
        check("R4 done on ack", fw_stat_rdata[0], 1);
        check("R6 irq on done", ep_irq, 1);
        in_token(v, c);
        check("R3 nak resp", {v, c}, {1'b1, 2'd1});
        fw_push(8'hB0);
        stat_write(4'b1111);
        in_token(v, c);
        bus_tx_pop = 1; @(negedge clk); bus_tx_pop = 0;
        pulse_tx_end();
        // clearing write and device set in the same cycle
        bus_host_ack = 1; fw_stat_wr = 1; fw_stat_wdata = 4'b0110;
        @(negedge clk);
        bus_host_ack = 0; fw_stat_wr = 0; fw_stat_wdata = 0;
        check("R5 set wins over clear", fw_stat_rdata[0], 1);
        stat_write(4'b0110);
        check("R5 write0 clears", fw_stat_rdata[0], 0);
        check("R6 irq drops", ep_irq, 0);
        pulse_ack();
        check("R4 stray ack ignored", fw_stat_rdata[0], 0);
        stat_write(4'b1111);
        check("R14 zlp count", cnt(), 0);
        in_token(v, c);
        check("R14 zlp data resp", {v, c}, {1'b1, 2'd2});
        pulse_tx_end();
        pulse_ack();
        check("R14 zlp done", fw_stat_rdata[0], 1);
        stat_write(4'b0110);
    endtask

    task automatic t_setup();
        logic v; logic [1:0] c;
        fw_push(8'h01); fw_push(8'h02);
        stat_write(4'b1111);
        rx_packet(1'b1, 8, 8'h10, v, c);
        check("R7 setup ack", {v, c}, {1'b1, 2'd0});
        check("R7 setup flag", fw_stat_rdata[1], 1);
        check("R7 tx_ready cancelled", fw_stat_rdata[3], 0);
        check("R7 setup count", cnt(), 8);
        check("R6 irq on setup", ep_irq, 1);
        check("R11 head first", fw_fifo_rdata, 8'h10);
        fw_pop();
        check("R11 head second", fw_fifo_rdata, 8'h11);
        fw_pop();
        check("R11 count after reads", cnt(), 6);
        rx_packet(1'b0, 4, 8'h40, v, c);
        check("R8 out nak", {v, c}, {1'b1, 2'd1});
        check("R8 fifo kept", cnt(), 6);
        check("R8 head kept", fw_fifo_rdata, 8'h12);
        check("R8 rx flag clear", fw_stat_rdata[2], 0);
        stat_write(4'b0101);
        check("R12 setup cleared", fw_stat_rdata[1], 0);
        check("R12 flushed", cnt(), 0);
        check("R6 irq idle", ep_irq, 0);
    endtask

    task automatic t_out();
        logic v; logic [1:0] c;
        rx_packet(1'b0, 5, 8'h60, v, c);
        check("R9 out ack", {v, c}, {1'b1, 2'd0});
        check("R9 rx flag", fw_stat_rdata[2], 1);
        check("R9 count", cnt(), 5);
        rx_packet(1'b0, 3, 8'h70, v, c);
        check("R10 nak when full", {v, c}, {1'b1, 2'd1});
        check("R10 count kept", cnt(), 5);
        for (int i = 0; i < 3; i++) begin
            check("R11 rx order", fw_fifo_rdata, 8'h60 + 8'(i));
            fw_pop();
        end
        stat_write(4'b0011);
        check("R12 rx flush", cnt(), 0);
        check("R12 rx flag clear", fw_stat_rdata[2], 0);
        fw_push(8'h33);
        stat_write(4'b1111);
        rx_packet(1'b0, 2, 8'h90, v, c);
        check("R10 nak when tx_ready", {v, c}, {1'b1, 2'd1});
        check("R10 tx data kept", fw_fifo_rdata, 8'h33);
        in_token(v, c);
        pulse_tx_end();
    endtask

    task automatic t_overflow();
        logic v; logic [1:0] c;
        rx_packet(1'b0, 70, 8'h00, v, c);
        check("R13 ack", {v, c}, {1'b1, 2'd0});
        check("R13 count saturates", cnt(), 64);
        check("R13 head", fw_fifo_rdata, 8'h00);
        stat_write(4'b0011);
        check("R13 cleared", cnt(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_in_path();
        t_setup();
        t_out();
        t_overflow();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule